// File: doc/BRIEF.md
# Memory Refresh Interval Timer

This block paces refresh for a DRAM bus controller. A free-running divider on the bus clock produces a count tick at one of seven fixed ratios. An 8-bit up-counter advances on each tick and is compared against a programmable 8-bit limit register. When the counter, holding the limit value, meets a tick, it wraps to zero and the block emits a one-cycle refresh request.

A status flag records that the limit was reached, and it can raise an interrupt when enabled. Software cannot clear the flag by a plain write. A write of 0 to the flag only arms a pending clear. The flag then drops when the bus controller reports a completed refresh while refresh is switched on and the normal (address-less, counter-driven) refresh mode is selected.

Software reaches three registers through a simple port with combinational read data: control/status at address 0, the counter at address 1 and the limit at address 2. Address 3 reads 0.

Top module: `refresh_timer`

## Requirements
- R1: After reset, the control/status, counter and limit registers read 0, irq and refresh_req are 0, and the counter does not advance while the clock-select field is 0.
- R2: Control/status bits 15:8 and 2:0 always read 0, and writes to them have no effect.
- R3: The clock-select field (bits 5:3) sets how many bus clocks pass between counter increments: 1→4, 2→16, 3→64, 4→256, 5→1024, 6→2048, 7→4096.
- R4: On a tick with the counter equal to the limit, the counter becomes 0 and refresh_req is high for exactly one cycle, so with limit C and ratio N the pulses are (C+1)·N cycles apart.
- R5: The flag (bit 7) becomes 1 on the tick that brings the counter to the limit value.
- R6: Writing 1 to the flag leaves it unchanged.
- R7: The flag clears only when refresh_done is high while a clear is pending (armed by writing 0 to bit 7), refresh_on is 1 and refresh_alt_mode is 0. refresh_done with no pending clear, or with the wrong mode, leaves it set.
- R8: If the flag's set condition and a clear event fall in the same cycle, the flag ends up 1.
- R9: irq equals the flag ANDed with the interrupt enable (bit 6).
- R10: A register write to the counter in the same cycle as a tick stores the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| reg_sel | input | 2 | Register address: 0 control/status, 1 counter, 2 limit |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_sel, combinational |
| refresh_on | input | 1 | Refresh enabled by the bus controller |
| refresh_alt_mode | input | 1 | 1 selects the alternative refresh mode; 0 the counter-driven mode |
| refresh_done | input | 1 | A refresh has been carried out |
| irq | output | 1 | Interrupt request |
| refresh_req | output | 1 | One-cycle refresh request |

## Verification
The assertions assume that refresh_done is never held high for consecutive refreshes faster than the shortest tick spacing. They also assume that software writes the counter only through the register port. The bench keeps refresh_done to single-cycle strobes and drives every register change through writes at the falling edge. The same-cycle set/clear case is placed by watching the counter step and counting the known four-cycle tick spacing, so no internal tick is probed.

// File: rtl/refresh_timer.sv
module refresh_timer #(
  parameter int CNT_W  = 8,
  parameter int DIV_W  = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              refresh_on,
  input  logic              refresh_alt_mode,
  input  logic              refresh_done,
  output logic              irq,
  output logic              refresh_req
);
  logic [DIV_W-1:0] div_q, div_mask;
  logic [CNT_W-1:0] cnt_q, lim_q, cnt_nxt;
  logic [2:0]       sel_q;
  logic [3:0]       div_lg;
  logic             flag_q, ie_q, pend_q, req_q;
  logic             tick, wr_ctl, wr_cnt, wr_lim, at_lim, wrap, set_ev, clr_ev;

  always_comb begin
    case (sel_q)
      3'd1:    div_lg = 4'd2;
      3'd2:    div_lg = 4'd4;
      3'd3:    div_lg = 4'd6;
      3'd4:    div_lg = 4'd8;
      3'd5:    div_lg = 4'd10;
      3'd6:    div_lg = 4'd11;
      default: div_lg = 4'd12;
    endcase
  end

  assign div_mask = (DIV_W'(1) << div_lg) - DIV_W'(1);
  assign tick     = (sel_q != 3'd0) && ((div_q & div_mask) == div_mask);

  assign wr_ctl  = reg_wr && (reg_sel == 2'd0);
  assign wr_cnt  = reg_wr && (reg_sel == 2'd1);
  assign wr_lim  = reg_wr && (reg_sel == 2'd2);
  assign at_lim  = (cnt_q == lim_q);
  assign cnt_nxt = at_lim ? '0 : cnt_q + CNT_W'(1);
  assign wrap    = tick && !wr_cnt && at_lim;
  assign set_ev  = tick && !wr_cnt && (cnt_nxt == lim_q);
  assign clr_ev  = refresh_done && pend_q && refresh_on && !refresh_alt_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      cnt_q  <= '0;
      lim_q  <= '0;
      sel_q  <= '0;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
      pend_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      div_q <= div_q + DIV_W'(1);
      req_q <= wrap;
      if (wr_cnt)      cnt_q <= reg_wdata[CNT_W-1:0];
      else if (tick)   cnt_q <= cnt_nxt;
      if (wr_lim)      lim_q <= reg_wdata[CNT_W-1:0];
      if (wr_ctl) begin
        ie_q  <= reg_wdata[6];
        sel_q <= reg_wdata[5:3];
      end
      if (set_ev)      flag_q <= 1'b1;
      else if (clr_ev) flag_q <= 1'b0;
      if (wr_ctl && !reg_wdata[7]) pend_q <= 1'b1;
      else if (clr_ev)             pend_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = DATA_W'({flag_q, ie_q, sel_q, 3'b000});
      2'd1:    reg_rdata = DATA_W'(cnt_q);
      2'd2:    reg_rdata = DATA_W'(lim_q);
      default: reg_rdata = '0;
    endcase
  end

  assign irq         = flag_q & ie_q;
  assign refresh_req = req_q;
endmodule

// File: rtl/refresh_timer_chk.sv
module refresh_timer_chk #(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        reg_sel,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              refresh_on,
  input logic              refresh_alt_mode,
  input logic              refresh_done,
  input logic              refresh_req,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [2:0]        sel_q,
  input logic              tick,
  input logic              flag_q
);
  // R4
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req |=> !refresh_req);

  // R4
  req_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req |-> cnt_q == '0);

  // R1
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == 3'd0 && !(reg_wr && reg_sel == 2'd1)) |=> $stable(cnt_q));

  // R5
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(tick));

  // R7
  flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(refresh_done && refresh_on && !refresh_alt_mode));

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel == 2'd0 |-> (reg_rdata[15:8] == 8'h00 && reg_rdata[2:0] == 3'b000));
endmodule

bind refresh_timer refresh_timer_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
  .reg_rdata(reg_rdata), .refresh_on(refresh_on),
  .refresh_alt_mode(refresh_alt_mode), .refresh_done(refresh_done),
  .refresh_req(refresh_req), .cnt_q(cnt_q), .sel_q(sel_q), .tick(tick),
  .flag_q(flag_q)
);

// File: tb/test_refresh_timer.sv
module test_refresh_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_sel = 2'd1;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        refresh_on = 1'b1;
  logic        refresh_alt_mode = 1'b0;
  logic        refresh_done = 1'b0;
  logic        irq, refresh_req;

  int total = 0;
  int bad = 0;
  longint cyc = 0;

  refresh_timer i_refresh_timer (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .refresh_on(refresh_on),
    .refresh_alt_mode(refresh_alt_mode), .refresh_done(refresh_done),
    .irq(irq), .refresh_req(refresh_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_sel = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 2'd1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_sel = a; #1; d = reg_rdata; reg_sel = 2'd1;
  endtask

  task automatic wait_cnt_change();
    logic [15:0] v;
    rd(2'd1, v);
    for (int i = 0; i < 10000; i++) begin
      @(negedge clk);
      if (reg_rdata != v) break;
    end
  endtask

  task automatic pulse_done();
    @(negedge clk); refresh_done = 1'b1;
    @(negedge clk); refresh_done = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(2'd0, d); check("R1 ctl", d, 0);
    rd(2'd1, d); check("R1 cnt", d, 0);
    rd(2'd2, d); check("R1 lim", d, 0);
    check("R1 irq", irq, 0);
    check("R1 req", refresh_req, 0);
    repeat (40) @(negedge clk);
    rd(2'd1, d); check("R1 stopped", d, 0);
  endtask

  task automatic t_reserved();
    logic [15:0] d;
    wr(2'd0, 16'hFF87);
    rd(2'd0, d); check("R2 reserved bits", d, 0);
    check("R6 write one", d[7], 0);
  endtask

  task automatic t_ratio();
    int ratio [1:7] = '{4, 16, 64, 256, 1024, 2048, 4096};
    longint t0;
    wr(2'd2, 16'h00FF);
    for (int c = 1; c <= 7; c++) begin
      wr(2'd1, 16'h0000);
      wr(2'd0, 16'h0080 | 16'(c << 3));
      wait_cnt_change();
      t0 = cyc;
      wait_cnt_change();
      check($sformatf("R3 code %0d", c), cyc - t0, ratio[c]);
    end
    wr(2'd0, 16'h0080);
  endtask

  task automatic t_wrap();
    longint t0;
    logic [15:0] d;
    wr(2'd2, 16'h0003);
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'h0088);
    for (int i = 0; i < 200 && !refresh_req; i++) @(negedge clk);
    t0 = cyc;
    rd(2'd1, d); check("R4 wrap to zero", d, 0);
    @(negedge clk); check("R4 one cycle", refresh_req, 0);
    for (int i = 0; i < 200 && !refresh_req; i++) @(negedge clk);
    check("R4 period", cyc - t0, 16);
    rd(2'd0, d); check("R5 flag set", d[7], 1);
    check("R9 masked", irq, 0);
  endtask

  task automatic t_clear();
    logic [15:0] d;
    wr(2'd0, 16'h00C0);
    check("R9 irq on", irq, 1);
    pulse_done();
    rd(2'd0, d); check("R7 no arm", d[7], 1);
    wr(2'd0, 16'h0040);
    rd(2'd0, d); check("R7 armed stays", d[7], 1);
    refresh_alt_mode = 1'b1; pulse_done(); refresh_alt_mode = 1'b0;
    rd(2'd0, d); check("R7 alt mode", d[7], 1);
    refresh_on = 1'b0; pulse_done(); refresh_on = 1'b1;
    rd(2'd0, d); check("R7 refresh off", d[7], 1);
    pulse_done();
    rd(2'd0, d); check("R7 cleared", d[7], 0);
    check("R9 irq off", irq, 0);
  endtask

  task automatic t_set_wins();
    logic [15:0] d;
    wr(2'd1, 16'h0000);
    wr(2'd2, 16'h0002);
    wr(2'd0, 16'h0008);
    wait_cnt_change();
    repeat (3) @(negedge clk);
    refresh_done = 1'b1;
    @(negedge clk);
    refresh_done = 1'b0;
    rd(2'd1, d); check("R8 align", d, 2);
    rd(2'd0, d); check("R8 set wins", d[7], 1);
    wr(2'd0, 16'h0080);
  endtask

  task automatic t_priority();
    logic [15:0] d;
    wr(2'd2, 16'h00FF);
    wr(2'd0, 16'h0088);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      reg_sel = 2'd1; reg_wdata = 16'h0050; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      rd(2'd1, d); check("R10 write priority", d, 16'h50);
    end
    wr(2'd0, 16'h0080);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=expired expected=done");
      end
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_reserved();
        t_ratio();
        t_wrap();
        t_clear();
        t_set_wins();
        t_priority();
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule